// File: doc/BRIEF.md
# Controller Operating-State Transition Engine

This block steers a memory controller from whatever operating state it happens to be in to a requested target state, either configuration or access. The controller reports its state through a small status field and accepts state-change commands. On a request the engine reads the status and issues the one command that moves the controller one hop closer to the target. It then waits until the status shows the state that hop leads to. After each completed hop it reads the status again and decides afresh, so paths of several hops come from repeated single decisions and are never a fixed script.

The engine reports completion with a one-cycle `done` pulse. If a hop's awaited state fails to appear within a parameterized number of cycles, it gives up and raises a sticky error flag together with `done`. A status code outside the four known ones is never acted on: the engine issues nothing and keeps sampling until a known code appears.

Top module: `opstate_walker`

## Requirements
- R1: While and right after a synchronous reset, `cmd_valid`, `done`, `busy` and `err` are all 0.
- R2: Encodings: status codes are 0 = memory-init, 1 = configuration, 3 = access and 4 = low-power, and every other code is unrecognized. Command codes are 1 = wake, 2 = configure and 3 = go. `req_target` 0 selects configuration and 1 selects access. With target configuration from low-power, the engine issues wake, waits for access, then issues configure and waits for configuration.
- R3: With target configuration from access or from memory-init, the engine issues only configure and waits for configuration. A go command is never issued while the target is configuration.
- R4: With target access from low-power, the engine issues only wake and waits for access.
- R5: With target access from memory-init, the engine issues configure, waits for configuration, then issues go and waits for access.
- R6: With target access from configuration, the engine issues only go and waits for access.
- R7: If the status already equals the target, no command is issued and `done` pulses for one cycle, visible in the second cycle after the request is taken.
- R8: While the status holds an unrecognized code, no command and no `done` are produced, `busy` stays 1, and the engine resumes normally once a known code appears.
- R9: `cmd_valid` is a one-cycle pulse. No further command follows until the awaited status of the previous hop has been observed.
- R10: If the awaited status has not appeared `TIMEOUT_CYCLES` cycles after a command pulse, `done` and `err` rise together in that cycle and the engine goes idle. `err` stays 1 until the next request is taken, and that request clears it.
- R11: A request that arrives while `busy` is 1 is ignored. The ongoing transition keeps its original target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_target | input | 1 | Target state: 0 configuration, 1 access |
| ctl_stat | input | STAT_W | Controller status field |
| cmd_valid | output | 1 | One-cycle command strobe to the controller |
| cmd_code | output | 2 | Command: 1 wake, 2 configure, 3 go |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky: last transition ended by timeout |

## Verification
Two situations are hard to reach from the ports. The first is a status that stays unrecognized for a long time. The second is a hop whose awaited state never comes. The bench acts as the controller: it answers each command after a chosen latency and sweeps every start state, both targets and several latencies. For the hard cases it holds an unknown code for many cycles before releasing it, and it withholds the answer to a wake command so the timeout fires. It also injects a conflicting request in the middle of a two-hop path.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

  typedef enum logic [1:0] {
    CS_INIT   = 2'd0,
    CS_CONFIG = 2'd1,
    CS_ACCESS = 2'd2,
    CS_LOWPWR = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    OC_NONE = 2'd0,
    OC_WAKE = 2'd1,
    OC_CFG  = 2'd2,
    OC_GO   = 2'd3
  } op_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_WAIT   = 2'd2
  } phase_e;

  localparam int CMD_W = 2;
  localparam logic TGT_CONFIG = 1'b0;
  localparam logic TGT_ACCESS = 1'b1;

endpackage

// File: rtl/opstate_decode.sv
module opstate_decode
  import opstate_pkg::*;
#(
  parameter int STAT_W = 3,
  parameter logic [STAT_W-1:0] CODE_INIT   = 'd0,
  parameter logic [STAT_W-1:0] CODE_CONFIG = 'd1,
  parameter logic [STAT_W-1:0] CODE_ACCESS = 'd3,
  parameter logic [STAT_W-1:0] CODE_LOWPWR = 'd4
) (
  input  logic [STAT_W-1:0] stat,
  output logic              known,
  output ctl_state_e        cls
);

  localparam int N_CODES = 4;

  logic [STAT_W-1:0] code_tab [N_CODES];
  logic [N_CODES-1:0] hit;

  assign code_tab[0] = CODE_INIT;
  assign code_tab[1] = CODE_CONFIG;
  assign code_tab[2] = CODE_ACCESS;
  assign code_tab[3] = CODE_LOWPWR;

  for (genvar i = 0; i < N_CODES; i++) begin : g_match
    assign hit[i] = (stat == code_tab[i]);
  end

  always_comb begin
    known = |hit;
    cls   = CS_INIT;
    if (hit[1]) cls = CS_CONFIG;
    if (hit[2]) cls = CS_ACCESS;
    if (hit[3]) cls = CS_LOWPWR;
  end

endmodule

// File: rtl/opstate_hop_plan.sv
module opstate_hop_plan
  import opstate_pkg::*;
(
  input  ctl_state_e cur,
  input  logic       tgt,
  output logic       at_tgt,
  output op_cmd_e    cmd,
  output ctl_state_e expect_st
);

  always_comb begin
    at_tgt    = 1'b0;
    cmd       = OC_NONE;
    expect_st = CS_INIT;
    unique case (cur)
      CS_LOWPWR: begin
        cmd       = OC_WAKE;
        expect_st = CS_ACCESS;
      end
      CS_INIT: begin
        cmd       = OC_CFG;
        expect_st = CS_CONFIG;
      end
      CS_ACCESS: begin
        if (tgt == TGT_ACCESS) begin
          at_tgt = 1'b1;
        end else begin
          cmd       = OC_CFG;
          expect_st = CS_CONFIG;
        end
      end
      CS_CONFIG: begin
        if (tgt == TGT_CONFIG) begin
          at_tgt = 1'b1;
        end else begin
          cmd       = OC_GO;
          expect_st = CS_ACCESS;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opstate_wait_timer.sv
module opstate_wait_timer #(
  parameter int LIMIT = 1024,
  parameter bit EN    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  if (EN) begin : g_timer
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst || clear) cnt_q <= '0;
      else if (run && cnt_q != CNT_W'(LIMIT - 1)) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(LIMIT - 1));
  end else begin : g_no_timer
    assign expired = 1'b0;
  end

endmodule

// File: rtl/opstate_walker.sv
module opstate_walker
  import opstate_pkg::*;
#(
  parameter int STAT_W = 3,
  parameter logic [STAT_W-1:0] CODE_INIT   = 'd0,
  parameter logic [STAT_W-1:0] CODE_CONFIG = 'd1,
  parameter logic [STAT_W-1:0] CODE_ACCESS = 'd3,
  parameter logic [STAT_W-1:0] CODE_LOWPWR = 'd4,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter bit TIMEOUT_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_target,
  input  logic [STAT_W-1:0] ctl_stat,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              busy,
  output logic              done,
  output logic              err
);

  phase_e     phase_q;
  logic       tgt_q;
  ctl_state_e exp_q;
  op_cmd_e    cmd_q;

  logic       stat_known;
  ctl_state_e stat_cls;
  logic       at_tgt;
  op_cmd_e    plan_cmd;
  ctl_state_e plan_exp;
  logic       hop_ok;
  logic       expired;

  opstate_decode #(
    .STAT_W(STAT_W), .CODE_INIT(CODE_INIT), .CODE_CONFIG(CODE_CONFIG),
    .CODE_ACCESS(CODE_ACCESS), .CODE_LOWPWR(CODE_LOWPWR)
  ) dec_i (
    .stat(ctl_stat), .known(stat_known), .cls(stat_cls)
  );

  opstate_hop_plan plan_i (
    .cur(stat_cls), .tgt(tgt_q), .at_tgt(at_tgt),
    .cmd(plan_cmd), .expect_st(plan_exp)
  );

  assign hop_ok = stat_known && (stat_cls == exp_q);

  opstate_wait_timer #(.LIMIT(TIMEOUT_CYCLES), .EN(TIMEOUT_EN)) tmr_i (
    .clk(clk), .rst(rst),
    .clear(phase_q != PH_WAIT),
    .run(phase_q == PH_WAIT && !hop_ok),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      tgt_q     <= TGT_CONFIG;
      exp_q     <= CS_INIT;
      cmd_q     <= OC_NONE;
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            tgt_q   <= req_target;
            err     <= 1'b0;
            phase_q <= PH_SAMPLE;
          end
        end
        PH_SAMPLE: begin
          if (stat_known) begin
            if (at_tgt) begin
              done    <= 1'b1;
              phase_q <= PH_IDLE;
            end else begin
              cmd_valid <= 1'b1;
              cmd_q     <= plan_cmd;
              exp_q     <= plan_exp;
              phase_q   <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (hop_ok) begin
            phase_q <= PH_SAMPLE;
          end else if (expired) begin
            err     <= 1'b1;
            done    <= 1'b1;
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign cmd_code = cmd_q;

  // R9
  cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SAMPLE && !stat_known) |=> (!cmd_valid && !done && busy));

  // R3
  cfg_never_go_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && tgt_q == TGT_CONFIG) |-> (cmd_code != OC_GO));

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  // R11
  busy_hold_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(tgt_q));

endmodule

// File: tb/opstate_walker_tb_top.sv
module opstate_walker_tb_top;
  localparam int STAT_W = 3;
  localparam int TMO    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_target = 1'b0;
  logic [STAT_W-1:0] ctl_stat = '0;
  logic cmd_valid, busy, done, err;
  logic [1:0] cmd_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opstate_walker #(.STAT_W(STAT_W), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
    .ctl_stat(ctl_stat), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [STAT_W-1:0] code_of(input int s);
    case (s)
      0: return 3'd0;
      1: return 3'd1;
      2: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] result_of(input logic [1:0] c);
    return (c == 2'd2) ? 3'd1 : 3'd3;
  endfunction

  // start index: 0 init, 1 config, 2 access, 3 low-power; t: 0 config, 1 access
  function automatic int plan_len(input int s, input bit t, output int c0, output int c1);
    c0 = 0; c1 = 0;
    if (!t) begin
      if (s == 3) begin c0 = 1; c1 = 2; return 2; end
      if (s == 1) return 0;
      c0 = 2; return 1;
    end else begin
      if (s == 3) begin c0 = 1; return 1; end
      if (s == 0) begin c0 = 2; c1 = 3; return 2; end
      if (s == 1) begin c0 = 3; return 1; end
      return 0;
    end
  endfunction

  function automatic string tag_of(input int s, input bit t);
    if (!t) return (s == 3) ? "R2" : (s == 1) ? "R7" : "R3";
    return (s == 3) ? "R4" : (s == 0) ? "R5" : (s == 1) ? "R6" : "R7";
  endfunction

  task automatic run_case(input int s, input bit t, input int lat, input bit inject);
    int c0, c1, n, got, cd, iters;
    int obs[4];
    bit pend, seen;
    logic [1:0] pc;
    string tg;
    n = plan_len(s, t, c0, c1);
    tg = tag_of(s, t);
    got = 0; cd = 0; iters = 0; pend = 0; seen = 0; pc = 0;
    @(negedge clk);
    ctl_stat = code_of(s); req_target = t; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      iters++;
      req_valid = 1'b0;
      if (cmd_valid) begin
        if (got < 4) obs[got] = cmd_code;
        got++;
        pend = 1; cd = lat; pc = cmd_code;
        if (inject && got == 1) begin req_valid = 1'b1; req_target = !t; end
      end
      if (pend) begin
        if (cd == 0) begin ctl_stat = result_of(pc); pend = 0; end
        else cd--;
      end
      if (done) begin seen = 1; break; end
    end
    req_valid = 1'b0;
    chk(seen, tg, seen, 1);
    chk(got == n, tg, got, n);
    if (n >= 1 && got >= 1) chk(obs[0] == c0, tg, obs[0], c0);
    if (n >= 2 && got >= 2) chk(obs[1] == c1, tg, obs[1], c1);
    chk(err == 1'b0, "R10", err, 0);
    if (n == 0) chk(iters == 1, "R7", iters, 1);
    if (inject) chk(ctl_stat == code_of(t ? 2 : 1), "R11", ctl_stat, code_of(t ? 2 : 1));
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    checks++; errors++;
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int wait_cnt, cmd_at, done_at, code_seen;
    bit quiet;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done && !busy && !err, "R1", {cmd_valid, done, busy, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmd_valid && !done && !busy && !err, "R1", {cmd_valid, done, busy, err}, 0);

    // sweep every start state, both targets and three latencies
    for (int lat = 0; lat < 3; lat++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 2; t++)
          run_case(s, t[0], lat, 1'b0);

    // R11: conflicting request injected mid-path
    run_case(3, 1'b0, 3, 1'b1);
    run_case(0, 1'b1, 2, 1'b1);

    // R8: unrecognized code held for a while, then access appears
    @(negedge clk);
    ctl_stat = 3'd6; req_target = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    quiet = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (cmd_valid || done || !busy) quiet = 0;
    end
    chk(quiet, "R8", quiet, 1);
    ctl_stat = 3'd3;
    code_seen = 0; quiet = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cmd_valid) begin code_seen = cmd_code; ctl_stat = 3'd1; end
      if (done) begin quiet = 1; break; end
    end
    chk(code_seen == 2, "R8", code_seen, 2);
    chk(quiet, "R8", quiet, 1);

    // R10: wake never answered
    @(negedge clk);
    ctl_stat = 3'd4; req_target = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cmd_at = -1; done_at = -1; code_seen = 0; wait_cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      wait_cnt++;
      if (cmd_valid) begin cmd_at = wait_cnt; code_seen = cmd_code; end
      if (done) begin done_at = wait_cnt; break; end
    end
    chk(code_seen == 1, "R10", code_seen, 1);
    chk(done_at - cmd_at == TMO, "R10", done_at - cmd_at, TMO);
    chk(err == 1'b1, "R10", err, 1);
    repeat (3) @(negedge clk);
    chk(err == 1'b1 && !busy, "R10", {err, busy}, 2);
    // next request clears err (checked inside run_case)
    run_case(2, 1'b1, 0, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule